// File: doc/BRIEF.md
# Mode Strap Capture and Shared Interrupt Pin Controller

This block serves a pin pair that does two jobs. While the chip is held in reset, both pins act as mode straps, and their levels go into a 2-bit operating-mode register. After reset ends and a programmable settle interval has passed, the first pin of the pair becomes an active-low external interrupt request. That request is asynchronous to the clock. Software may overwrite the mode register at any time once reset has ended.

The interrupt side brings the request pin into the clock domain through a synchronizer. It can run in one of two modes. In level mode, the pending flag tracks the synchronized low level. In falling-edge mode, a falling edge sets a sticky pending flag, and an acknowledge input clears it. A separate wake output follows the raw pin level. It is meant to bring the device out of its stop state without needing a running clock. Both the pending flag and the wake output stay quiet until the settle interval has expired, so strap activity around reset raises nothing.

Top module: `modepin_irq_ctrl`

## Requirements
- R1: `op_mode` bit 0 takes the level of `mode_a_irq_n` and bit 1 takes the level of `mode_b`. Both are sampled on every clock edge while `rst_n` is low and for two edges after it rises. After that, the value is held.
- R2: Once the internal reset has been released (two edges after `rst_n` rises), asserting `sw_mode_we` loads `sw_mode_wdata` into `op_mode` on the next edge. Before that point, `sw_mode_we` has no effect.
- R3: `irq_live` goes high exactly SETTLE_CYCLES+2 rising edges after `rst_n` is released. It then stays high until the next reset.
- R4: While `irq_live` is low, `irq_pending` and `wake` are low whatever the pin does.
- R5: In level mode (`trig_edge`=0), `irq_pending` goes high on the second edge after the pin goes low. It goes low on the second edge after the pin returns high (two-stage synchronizer).
- R6: In falling-edge mode (`trig_edge`=1), a falling edge on the pin sets `irq_pending` on the third edge after the fall. The flag stays set while the pin stays low and after the pin rises. A low pulse lasting one clock is enough to set it.
- R7: In falling-edge mode, `irq_ack` clears `irq_pending` on the next edge. If a new falling edge is detected in the same cycle as the acknowledge, the flag stays set.
- R8: In falling-edge mode, a pin held low after an acknowledge does not set the flag again. A rising edge never sets it.
- R9: `wake` is high exactly when `in_stop` is high, `irq_live` is high and the raw pin is low. It responds without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_a_irq_n | input | 1 | Mode strap A during reset; active-low interrupt request afterwards |
| mode_b | input | 1 | Mode strap B |
| sw_mode_we | input | 1 | Software write strobe for the mode register |
| sw_mode_wdata | input | 2 | Software write value for the mode register |
| trig_edge | input | 1 | 0 = level triggering, 1 = falling-edge triggering |
| irq_ack | input | 1 | Clears a latched edge interrupt |
| in_stop | input | 1 | Device is in its stop state |
| op_mode | output | 2 | Operating mode {strap B, strap A} |
| irq_live | output | 1 | Settle interval has expired and detection is enabled |
| irq_pending | output | 1 | Interrupt pending flag |
| wake | output | 1 | Request to leave the stop state |

## Verification
The bench goes through reset with all four strap combinations. It also drives a conflicting software write during reset, which separates straps that were genuinely sampled from writes that leaked through early. While the settle interval runs, it toggles the request pin with stop asserted, which shows that detection really is held off. In level mode, it applies low pulses of several widths so that the pending flag is seen to follow the pin with the synchronizer delay. In edge mode, it applies a long low, a one-clock glitch, a rising edge, a held-low level after acknowledge, and an acknowledge that coincides with a new fall; these patterns separate sticky capture from level following. A sweep over stop and pin level checks the combinational wake path.

// File: rtl/modepin_pkg.sv
package modepin_pkg;
  typedef logic [1:0] op_mode_t;

  function automatic op_mode_t strap_pack(input logic strap_b, input logic strap_a);
    return {strap_b, strap_a};
  endfunction
endpackage

// File: rtl/mp_reset_sync.sv
module mp_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_run
);
  logic [STAGES-1:0] run_q;
  logic [STAGES-1:0] run_d;

  always_comb begin
    run_d = {run_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign core_run = run_q[STAGES-1];
endmodule

// File: rtl/mp_mode_reg.sv
module mp_mode_reg
  import modepin_pkg::*;
(
  input  logic     clk,
  input  logic     core_run,
  input  logic     strap_a,
  input  logic     strap_b,
  input  logic     wr_en,
  input  op_mode_t wr_data,
  output op_mode_t mode
);
  op_mode_t mode_q;
  op_mode_t mode_d;

  // Sampling must continue while reset is active, so this register
  // is deliberately left without an asynchronous clear.
  always_comb begin
    if (!core_run)   mode_d = strap_pack(strap_b, strap_a);
    else if (wr_en)  mode_d = wr_data;
    else             mode_d = mode_q;
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/mp_settle_timer.sv
module mp_settle_timer #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_run,
  output logic live
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign live   = (cnt_q == LIMIT);
  assign cnt_en = core_run && !live;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mp_irq_detect.sv
module mp_irq_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic req_n,
  input  logic trig_edge,
  input  logic ack,
  input  logic in_stop,
  output logic pending,
  output logic wake
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   latch_q;
  logic                   latch_d;
  logic                   lvl_n;
  logic                   fall;

  assign lvl_n = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q && !lvl_n;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], req_n};
  end

  always_comb begin
    latch_d = 1'b0;
    if (live && trig_edge) latch_d = (latch_q && !ack) || fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= lvl_n;
      latch_q <= latch_d;
    end
  end

  assign pending = trig_edge ? latch_q : (live && !lvl_n);
  assign wake    = in_stop && live && !req_n;
endmodule

// File: rtl/modepin_irq_ctrl.sv
module modepin_irq_ctrl
  import modepin_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int RST_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_a_irq_n,
  input  logic       mode_b,
  input  logic       sw_mode_we,
  input  logic [1:0] sw_mode_wdata,
  input  logic       trig_edge,
  input  logic       irq_ack,
  input  logic       in_stop,
  output logic [1:0] op_mode,
  output logic       irq_live,
  output logic       irq_pending,
  output logic       wake
);
  logic core_run;

  mp_reset_sync #(.STAGES(RST_STAGES)) u_rsync (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_run (core_run)
  );

  mp_mode_reg u_mode (
    .clk      (clk),
    .core_run (core_run),
    .strap_a  (mode_a_irq_n),
    .strap_b  (mode_b),
    .wr_en    (sw_mode_we),
    .wr_data  (sw_mode_wdata),
    .mode     (op_mode)
  );

  mp_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_run (core_run),
    .live     (irq_live)
  );

  mp_irq_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .live      (irq_live),
    .req_n     (mode_a_irq_n),
    .trig_edge (trig_edge),
    .ack       (irq_ack),
    .in_stop   (in_stop),
    .pending   (irq_pending),
    .wake      (wake)
  );
endmodule

// File: rtl/modepin_irq_ctrl_chk.sv
module modepin_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_a_irq_n,
  input logic       sw_mode_we,
  input logic [1:0] sw_mode_wdata,
  input logic       trig_edge,
  input logic       irq_ack,
  input logic       in_stop,
  input logic [1:0] op_mode,
  input logic       irq_live,
  input logic       irq_pending,
  input logic       wake
);
  // R4
  no_early_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_live |-> (!irq_pending && !wake));

  // R9
  wake_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (in_stop && irq_live && !mode_a_irq_n));

  // R3
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_live |=> irq_live);

  // R2
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_live && sw_mode_we) |=> (op_mode == $past(sw_mode_wdata)));

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_live && $past(irq_live) && !$past(sw_mode_we)) |-> $stable(op_mode));

  // R6
  sticky_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_edge && irq_live && irq_pending && !irq_ack) |=> (irq_pending || !trig_edge));
endmodule

bind modepin_irq_ctrl modepin_irq_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_a_irq_n  (mode_a_irq_n),
  .sw_mode_we    (sw_mode_we),
  .sw_mode_wdata (sw_mode_wdata),
  .trig_edge     (trig_edge),
  .irq_ack       (irq_ack),
  .in_stop       (in_stop),
  .op_mode       (op_mode),
  .irq_live      (irq_live),
  .irq_pending   (irq_pending),
  .wake          (wake)
);

// File: tb/tb_modepin_irq_ctrl.sv
`timescale 1ns/1ps
module tb_modepin_irq_ctrl;
  localparam int SETTLE = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_a_irq_n;
  logic       mode_b;
  logic       sw_mode_we;
  logic [1:0] sw_mode_wdata;
  logic       trig_edge;
  logic       irq_ack;
  logic       in_stop;
  logic [1:0] op_mode;
  logic       irq_live;
  logic       irq_pending;
  logic       wake;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  modepin_irq_ctrl #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_a_irq_n  (mode_a_irq_n),
    .mode_b        (mode_b),
    .sw_mode_we    (sw_mode_we),
    .sw_mode_wdata (sw_mode_wdata),
    .trig_edge     (trig_edge),
    .irq_ack       (irq_ack),
    .in_stop       (in_stop),
    .op_mode       (op_mode),
    .irq_live      (irq_live),
    .irq_pending   (irq_pending),
    .wake          (wake)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_pend(input string req, input bit exp);
    check(irq_pending == exp, req, int'(irq_pending), int'(exp));
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int first_live;
    rst_n = 1'b0; mode_a_irq_n = 1'b1; mode_b = 1'b0; sw_mode_we = 1'b0;
    sw_mode_wdata = 2'b00; trig_edge = 1'b0; irq_ack = 1'b0; in_stop = 1'b0;

    // Reset sweep over all strap values
    for (int m = 0; m < 4; m++) begin
      @(posedge clk); #1;
      rst_n = 1'b0;
      mode_a_irq_n = m[0]; mode_b = m[1];
      sw_mode_we = 1'b1; sw_mode_wdata = ~m[1:0];  // R2: ignored during reset
      in_stop = 1'b1; trig_edge = m[0];
      for (int i = 0; i < 4; i++) tick();
      check(irq_live == 1'b0, "R3 reset", int'(irq_live), 0);
      check(irq_pending == 1'b0, "R4 reset", int'(irq_pending), 0);
      @(negedge clk);
      rst_n = 1'b1;
      first_live = 0;
      for (int k = 1; k <= SETTLE + 4; k++) begin
        tick();
        if (k == 2) sw_mode_we = 1'b0;
        if (k == 3) check(op_mode == m[1:0], "R1 strap capture", int'(op_mode), m);
        if (irq_live && first_live == 0) first_live = k;
        if (!irq_live) begin
          check(!irq_pending && !wake, "R4 quiet before live",
                int'({irq_pending, wake}), 0);
        end
        if (k >= 3 && k <= 6) mode_a_irq_n = ~mode_a_irq_n;
        if (k == 7) mode_a_irq_n = 1'b1;
      end
      check(first_live == SETTLE + 2, "R3 settle count", first_live, SETTLE + 2);
      check(op_mode == m[1:0], "R1 hold after straps move", int'(op_mode), m);
    end

    in_stop = 1'b0; trig_edge = 1'b0; mode_a_irq_n = 1'b1;
    for (int i = 0; i < 3; i++) tick();

    // R2: software writes after reset
    for (int v = 0; v < 4; v++) begin
      sw_mode_we = 1'b1; sw_mode_wdata = v[1:0];
      tick();
      sw_mode_we = 1'b0; sw_mode_wdata = ~v[1:0];
      check(op_mode == v[1:0], "R2 write", int'(op_mode), v);
      tick();
      check(op_mode == v[1:0], "R2 hold without strobe", int'(op_mode), v);
    end

    // R9: wake sweep
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 2; p++) begin
        in_stop = s[0]; mode_a_irq_n = p[0];
        #0.5;
        check(wake == (s[0] && !p[0]), "R9 wake", int'(wake), int'(s[0] && !p[0]));
      end
    end
    in_stop = 1'b0; mode_a_irq_n = 1'b1;
    for (int i = 0; i < 3; i++) tick();

    // R5: level mode, several low widths
    trig_edge = 1'b0;
    for (int w = 1; w <= 3; w++) begin
      mode_a_irq_n = 1'b0;
      for (int j = 1; j <= w + 1; j++) begin
        tick();
        chk_pend("R5 level follow low", j >= 2);
      end
      mode_a_irq_n = 1'b1;
      tick(); chk_pend("R5 level release delay", 1'b1);
      tick(); chk_pend("R5 level release", 1'b0);
      tick();
    end

    // R6: edge mode, long low
    trig_edge = 1'b1;
    tick();
    mode_a_irq_n = 1'b0;
    tick(); chk_pend("R6 edge latency e1", 1'b0);
    tick(); chk_pend("R6 edge latency e2", 1'b0);
    tick(); chk_pend("R6 edge set", 1'b1);
    for (int i = 0; i < 4; i++) begin
      tick(); chk_pend("R6 sticky while low", 1'b1);
    end
    // R7: acknowledge clears
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk_pend("R7 ack clears", 1'b0);
    // R8: held low does not re-set
    for (int i = 0; i < 3; i++) begin
      tick(); chk_pend("R8 held low", 1'b0);
    end
    mode_a_irq_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick(); chk_pend("R8 rising edge", 1'b0);
    end

    // R6: one-clock glitch is captured and stays after pin rises
    mode_a_irq_n = 1'b0; tick(); mode_a_irq_n = 1'b1;
    tick(); tick();
    chk_pend("R6 glitch set", 1'b1);
    for (int i = 0; i < 3; i++) begin
      tick(); chk_pend("R6 sticky after rise", 1'b1);
    end

    // R7: new fall coincides with ack
    mode_a_irq_n = 1'b0; tick(); tick();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk_pend("R7 fall beats ack", 1'b1);
    tick(); chk_pend("R7 kept after ack", 1'b1);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk_pend("R7 second ack clears", 1'b0);
    mode_a_irq_n = 1'b1;
    for (int i = 0; i < 3; i++) tick();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule